// File: doc/BRIEF.md
# Expansion Memory Card Configuration Responder

This block is the configuration-space half of an expansion memory card on a 16-bit bus with a 24-bit address. After reset the card is unconfigured. It answers bus cycles in a 64 KB configuration window at `$E80000`–`$E8FFFF`. A host reads the card's identity there one nybble at a time: type, size code and manufacturer number. The host then writes a base address to the card. From that point the card no longer answers in configuration space. Instead it decodes a RAM window of the selected size at that base and asserts a select line for the RAM array.

A strap input selects the card's memory size: none, 1 MB, 2 MB, 4 MB or 8 MB. With "none" the card never appears. The host can also dismiss the card without mapping it, using a shut-up write. The RAM array and the bus master are outside this block.

Top module: `expcard_cfg_responder`

## Requirements
- R1: A bus cycle is answered in configuration space only while the card is visible and address bits 23..16 equal `$E8`. A read that is not answered loads `rdata` with `$0000` one cycle after the strobe.
- R2: An answered read loads `rdata` one cycle after the strobe with `$0FFF | (n << 12)`, where n is the 4-bit register value.
- R3: Register offset `$00` returns n = `$E`.
- R4: Offset `$02` returns the size code. `size_sel` encodes 1=1 MB, 2=2 MB, 3=4 MB and 4=8 MB, which give codes 5, 6, 7 and 0.
- R5: The register offset is address bits 7..1 with bit 0 taken as zero. Bits 15..8 and bit 0 are ignored. Offsets `$10`/`$12` return `$A`, offsets `$14`/`$16` return `$B`, and every other offset apart from `$00` and `$02` returns `$F`.
- R6: A configuration write to offset `$48` takes `wdata[15:8]` as base address bits 23..16, maps the RAM window and makes the card invisible.
- R7: A configuration write to offset `$4C` or `$4E` (address bits 7..0 from `$4C` to `$4F`) makes the card invisible and leaves it unmapped.
- R8: With `size_sel` 0 (or 5 to 7) the card is never visible, and every read returns `$0000`.
- R9: After reset the card is visible (unless the size is none), the RAM window is unmapped, `rdata` is `$0000` and `ram_sel` is low.
- R10: Once mapped, `ram_sel` is high in a strobe cycle, for a read or a write, exactly when base·65536 ≤ address < base·65536 + size. The size is 2^(19+`size_sel`) bytes.
- R11: The mapping takes effect in the cycle after the base write. `ram_sel` stays low during the base-write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| size_sel | input | 3 | Memory size strap (0 none, 1..4 = 1/2/4/8 MB) |
| bus_stb | input | 1 | Bus cycle strobe, one cycle per access |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 24 | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered, updated on each strobe |
| ram_sel | output | 1 | RAM array select, combinational in the strobe cycle |

## Verification
Two functions can coincide in one cycle: the base write that retires the card from configuration space, and the RAM window decode for that same address. The bench provokes this by mapping the window at `$E8`, so that the window covers configuration space. In the base-write cycle `ram_sel` must stay low. The next access to a `$E8xxxx` address must assert `ram_sel` and must return `$0000` instead of an ID nybble. The bench also maps at `$F8` with 8 MB, where the window's top would run past the address range, and checks both edges of every window it maps.

// File: rtl/expcard_pkg.sv
package expcard_pkg;

  typedef enum logic [2:0] {
    SZ_NONE = 3'd0,
    SZ_1M   = 3'd1,
    SZ_2M   = 3'd2,
    SZ_4M   = 3'd3,
    SZ_8M   = 3'd4
  } size_e;

  // A strap value outside 1..4 means no memory is fitted.
  function automatic logic size_present(input logic [2:0] s);
    return (s >= 3'd1) && (s <= 3'd4);
  endfunction

  // Nybble reported in the type-low register.
  function automatic logic [3:0] size_code(input logic [2:0] s);
    case (s)
      3'd1:    return 4'd5;
      3'd2:    return 4'd6;
      3'd3:    return 4'd7;
      3'd4:    return 4'd0;
      default: return 4'hF;
    endcase
  endfunction

  // Window length in bytes: 2^(19+s).
  function automatic logic [31:0] size_span(input logic [2:0] s);
    if (size_present(s)) return 32'd1 << (32'd19 + 32'(s));
    return 32'd0;
  endfunction

endpackage

// File: rtl/expcard_id_rom.sv
module expcard_id_rom
  import expcard_pkg::*;
#(
  parameter int          OFF_W  = 8,
  parameter logic [3:0]  MFG_HI = 4'hA,
  parameter logic [3:0]  MFG_LO = 4'hB
) (
  input  logic [OFF_W-1:0] reg_off,
  input  logic [2:0]       size_sel,
  output logic [3:0]       nybble
);

  always_comb begin
    case (reg_off)
      8'h00:          nybble = 4'hC | 4'h2;   // card type plus free-pool link flag
      8'h02:          nybble = size_code(size_sel);
      8'h10, 8'h12:   nybble = MFG_HI;
      8'h14, 8'h16:   nybble = MFG_LO;
      default:        nybble = 4'hF;
    endcase
  end

endmodule

// File: rtl/expcard_cfg_ctrl.sv
module expcard_cfg_ctrl #(
  parameter int OFF_W  = 8,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present,
  input  logic              cfg_wr,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [BASE_W-1:0] base_in,
  output logic              visible,
  output logic              mapped,
  output logic [BASE_W-1:0] base
);

  logic              vis_q, vis_d;
  logic              map_q, map_d;
  logic [BASE_W-1:0] base_q, base_d;
  logic              base_en;

  always_comb begin
    vis_d   = vis_q;
    map_d   = map_q;
    base_d  = base_q;
    base_en = 1'b0;
    if (cfg_wr) begin
      if (reg_off == 8'h48) begin
        base_d  = base_in;
        base_en = 1'b1;
        map_d   = 1'b1;
        vis_d   = 1'b0;
      end else if (reg_off == 8'h4C || reg_off == 8'h4E) begin
        vis_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vis_q  <= 1'b1;
      map_q  <= 1'b0;
      base_q <= '0;
    end else begin
      vis_q <= vis_d;
      map_q <= map_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign visible = vis_q & present;
  assign mapped  = map_q;
  assign base    = base_q;

  // R6 / R7: the card only leaves configuration space after a config write.
  assert_vis_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vis_q) |-> $past(cfg_wr));

  assert_map_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(map_q) |-> $past(cfg_wr && reg_off == 8'h48));

  assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (map_q && $past(map_q)) |-> $stable(base_q));

endmodule

// File: rtl/expcard_win_dec.sv
module expcard_win_dec
  import expcard_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BASE_W = 8
) (
  input  logic              stb,
  input  logic              mapped,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic [2:0]        size_sel,
  output logic              hit
);

  localparam int LOW_W = ADDR_W - BASE_W;

  logic [ADDR_W:0] diff;
  logic [31:0]     span;

  always_comb begin
    diff = {1'b0, addr} - {1'b0, base, {LOW_W{1'b0}}};
    span = size_span(size_sel);
    hit  = stb && mapped && !diff[ADDR_W] && (32'(diff[ADDR_W-1:0]) < span);
  end

endmodule

// File: rtl/expcard_cfg_responder.sv
module expcard_cfg_responder
  import expcard_pkg::*;
#(
  parameter int          ADDR_W   = 24,
  parameter int          DATA_W   = 16,
  parameter int          WIN_LSB  = 16,
  parameter int unsigned CFG_PAGE = 'hE8,
  parameter logic [3:0]  MFG_HI   = 4'hA,
  parameter logic [3:0]  MFG_LO   = 4'hB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        size_sel,
  input  logic              bus_stb,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ram_sel
);

  localparam int PAGE_W = ADDR_W - WIN_LSB;
  localparam int OFF_W  = 8;
  localparam int NYB_LSB = DATA_W - 4;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              present, in_cfg, cfg_rd, cfg_wr;
  logic [OFF_W-1:0]  reg_off;
  logic [3:0]        nybble;
  logic              visible, mapped;
  logic [PAGE_W-1:0] base;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign present = size_present(size_sel);
  assign in_cfg  = (bus_addr[ADDR_W-1:WIN_LSB] == PAGE_W'(CFG_PAGE));
  assign reg_off = {bus_addr[OFF_W-1:1], 1'b0};
  assign cfg_rd  = bus_stb &  bus_rd & visible & in_cfg;
  assign cfg_wr  = bus_stb & ~bus_rd & visible & in_cfg;

  expcard_id_rom #(.OFF_W(OFF_W), .MFG_HI(MFG_HI), .MFG_LO(MFG_LO)) u_rom (
    .reg_off (reg_off),
    .size_sel(size_sel),
    .nybble  (nybble)
  );

  expcard_cfg_ctrl #(.OFF_W(OFF_W), .BASE_W(PAGE_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .present(present),
    .cfg_wr (cfg_wr),
    .reg_off(reg_off),
    .base_in(wdata[DATA_W-1:DATA_W-PAGE_W]),
    .visible(visible),
    .mapped (mapped),
    .base   (base)
  );

  expcard_win_dec #(.ADDR_W(ADDR_W), .BASE_W(PAGE_W)) u_dec (
    .stb     (bus_stb),
    .mapped  (mapped),
    .addr    (bus_addr),
    .base    (base),
    .size_sel(size_sel),
    .hit     (ram_sel)
  );

  always_comb begin
    rdata_d = '0;
    if (cfg_rd) rdata_d = {nybble, {NYB_LSB{1'b1}}};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (bus_stb) rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

  // R2: an answered read leaves the low data lines all ones.
  assert_rd_fill_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(bus_stb && bus_rd && visible && in_cfg) |-> (rdata[NYB_LSB-1:0] == {NYB_LSB{1'b1}}));

  // R8: a card with no memory never drives an ID word.
  assert_none_quiet_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(!present && bus_stb) |-> (rdata == '0));

  // R10: the RAM window and configuration space never answer together.
  assert_sel_excl_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_sel |-> !visible);

endmodule

// File: tb/test_expcard_cfg_responder.sv
module test_expcard_cfg_responder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  size_sel;
  logic        bus_stb;
  logic        bus_rd;
  logic [23:0] bus_addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        ram_sel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  expcard_cfg_responder i_expcard_cfg_responder (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .bus_stb(bus_stb),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .wdata(wdata),
    .rdata(rdata), .ram_sel(ram_sel)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_nyb(input logic [7:0] off, input logic [2:0] s);
    logic [7:0] o;
    o = off & 8'hFE;
    if (o == 8'h00) return 4'hE;
    if (o == 8'h02) return (s == 3'd1) ? 4'd5 : (s == 3'd2) ? 4'd6 : (s == 3'd3) ? 4'd7 : 4'd0;
    if (o == 8'h10 || o == 8'h12) return 4'hA;
    if (o == 8'h14 || o == 8'h16) return 4'hB;
    return 4'hF;
  endfunction

  task automatic bus(input bit rd, input logic [23:0] a, input logic [15:0] d,
                     output bit sel, output logic [15:0] q);
    @(negedge clk);
    bus_stb = 1'b1; bus_rd = rd; bus_addr = a; wdata = d;
    #1 sel = ram_sel;
    @(negedge clk);
    bus_stb = 1'b0;
    q = rdata;
  endtask

  task automatic do_reset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0; size_sel = s; bus_stb = 1'b0; bus_rd = 1'b1; bus_addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset(input logic [2:0] s);
    bit sel; logic [15:0] q;
    do_reset(s);
    check(rdata == 16'h0000, "R9 rdata after reset", rdata, 0);
    bus(1'b1, 24'h000000, 16'h0, sel, q);
    check(sel == 1'b0, "R9 unmapped after reset", sel, 0);
  endtask

  task automatic t_id(input logic [2:0] s);
    bit sel; logic [15:0] q;
    do_reset(s);
    for (int o = 0; o < 256; o += 2) begin
      bus(1'b1, 24'hE80000 | 24'(o), 16'h0, sel, q);
      check(q == {exp_nyb(8'(o), s), 12'hFFF}, "R2 R3 R4 R5 ID read", q, {exp_nyb(8'(o), s), 12'hFFF});
    end
    bus(1'b1, 24'hE8A703, 16'h0, sel, q);
    check(q == {exp_nyb(8'h02, s), 12'hFFF}, "R4 size code via aliased address", q, {exp_nyb(8'h02, s), 12'hFFF});
    bus(1'b1, 24'hE85511, 16'h0, sel, q);
    check(q == 16'hAFFF, "R5 offset bit 0 ignored", q, 16'hAFFF);
    bus(1'b1, 24'hE90000, 16'h0, sel, q);
    check(q == 16'h0000, "R1 above config window", q, 0);
    bus(1'b1, 24'hE7FFFE, 16'h0, sel, q);
    check(q == 16'h0000, "R1 below config window", q, 0);
    bus(1'b0, 24'hE80040, 16'h1234, sel, q);
    bus(1'b1, 24'hE80000, 16'h0, sel, q);
    check(q == 16'hEFFF, "R7 other offset write leaves card visible", q, 16'hEFFF);
  endtask

  task automatic probe(input logic [23:0] a, input bit rd, input logic [31:0] lo, input logic [31:0] hi);
    bit sel; logic [15:0] q; bit e;
    e = (32'(a) >= lo) && (32'(a) < hi);
    bus(rd, a, 16'h5555, sel, q);
    check(sel == e, "R10 window decode", {8'h0, a}, {31'h0, e});
  endtask

  task automatic t_map(input logic [2:0] s, input logic [7:0] b);
    bit sel; logic [15:0] q; logic [31:0] lo, hi;
    lo = 32'(b) << 16;
    hi = lo + (32'd1 << (19 + 32'(s)));
    do_reset(s);
    bus(1'b0, 24'hE80049, {b, 8'h77}, sel, q);
    check(sel == 1'b0, "R11 no select in base-write cycle", sel, 0);
    bus(1'b1, 24'hE80000, 16'h0, sel, q);
    check(q == 16'h0000, "R6 config space gone after base write", q, 0);
    check(sel == (b == 8'hE8), "R10 config page select after map", sel, (b == 8'hE8));
    if (lo > 0) probe(24'(lo - 1), 1'b1, lo, hi);
    probe(24'(lo), 1'b1, lo, hi);
    probe(24'(lo), 1'b0, lo, hi);
    if (hi <= 32'h1000000) begin
      probe(24'(hi - 1), 1'b0, lo, hi);
      if (hi < 32'h1000000) probe(24'(hi), 1'b1, lo, hi);
    end else begin
      probe(24'hFFFFFF, 1'b1, lo, hi);
    end
  endtask

  task automatic t_shutup;
    bit sel; logic [15:0] q;
    do_reset(3'd2);
    bus(1'b0, 24'hE8004F, 16'hFF00, sel, q);
    bus(1'b1, 24'hE80002, 16'h0, sel, q);
    check(q == 16'h0000, "R7 shut-up hides card", q, 0);
    bus(1'b1, 24'h000000, 16'h0, sel, q);
    check(sel == 1'b0, "R7 shut-up leaves window unmapped", sel, 0);
    bus(1'b0, 24'hE80048, 16'h2000, sel, q);
    bus(1'b1, 24'h200000, 16'h0, sel, q);
    check(sel == 1'b0, "R7 base write ignored after shut-up", sel, 0);
  endtask

  task automatic t_none(input logic [2:0] s);
    bit sel; logic [15:0] q;
    do_reset(s);
    bus(1'b1, 24'hE80000, 16'h0, sel, q);
    check(q == 16'h0000, "R8 no-memory card silent", q, 0);
    bus(1'b0, 24'hE80048, 16'h2000, sel, q);
    bus(1'b1, 24'h200000, 16'h0, sel, q);
    check(sel == 1'b0, "R8 no-memory card never maps", sel, 0);
  endtask

  initial begin
    rst_n = 1'b0; size_sel = 3'd2; bus_stb = 1'b0; bus_rd = 1'b1; bus_addr = '0; wdata = '0;
    t_reset(3'd2);
    for (int s = 1; s <= 4; s++) t_id(3'(s));
    t_map(3'd1, 8'h20);
    t_map(3'd2, 8'h00);
    t_map(3'd3, 8'h40);
    t_map(3'd4, 8'hF8);
    t_map(3'd1, 8'hE8);
    t_shutup;
    t_none(3'd0);
    t_none(3'd6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule